// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block takes eight interrupt request lines and decides which one may raise the single interrupt output. It keeps three registers: the captured requests, a mask, and the set of levels that are currently in service. Priority is a ring. One register holds the level that currently has the lowest priority, and the level just after it in the ring has the highest. The ring can stay fixed, move onto a level as that level finishes service, or be placed explicitly by a command.

A host writes the mask as a whole byte. It sends commands on a 3-bit field {rot, sel, eoi} with a level operand, and it pulses an acknowledge strobe to take the current winner into service. An automatic end-of-interrupt option lets an acknowledged level leave service at once, without a command. That option can also rotate the ring onto the acknowledged level. Requests are captured either on rising edges or as levels, chosen by one input.

Top module: `prio_irq_resolver`

## Requirements
- R1: After reset, the request, mask and in-service registers are all zero, and the lowest-priority level is 7, so level 0 ranks highest. `irq_o` and `win_valid_o` are low.
- R2: With lowest level L, the priority order runs L+1, L+2, … wrapping modulo 8 and ending at L. `win_lvl_o` names the unmasked pending level that comes first in this order, and `win_valid_o` is high when such a level exists.
- R3: `mask_we_i` writes all eight bits of `mask_data_i` into the mask. A mask bit of 1 keeps that level out of the winner choice.
- R4: `irq_o` is high only when a winner exists and it ranks strictly above every in-service level. A winner of equal or lower rank leaves `irq_o` low.
- R5: A cycle with `ack_i` high while `irq_o` is high sets the winner's in-service bit (when automatic EOI is off) and clears its request bit. An acknowledge while `irq_o` is low changes nothing.
- R6: Command 001 clears the in-service bit that ranks highest. Command 101 does the same and also makes that level the lowest. When no bit is in service, both commands do nothing.
- R7: Command 011 clears the in-service bit selected by `cmd_lvl_i`. Command 111 does the same and also makes that level the lowest.
- R8: Command 110 makes `cmd_lvl_i` the lowest level and leaves the in-service register unchanged.
- R9: With `aeoi_en_i` high, an acknowledge clears the request bit and sets no in-service bit. Command 100 turns on rotate-on-automatic-EOI, under which the acknowledged level becomes the lowest. Command 000 turns it off.
- R10: With `level_mode_i` low, a request bit is set by a rising edge on its line and stays set after the line falls. A line that is held high does not set the bit again. With `level_mode_i` high, the request register follows the lines, and a bit cleared by an acknowledge returns one cycle later if its line is still high.
- R11: Command 010 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | 8 | Request lines, bit n is level n |
| level_mode_i | input | 1 | 1 = level capture, 0 = rising-edge capture |
| aeoi_en_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| mask_we_i | input | 1 | Mask write strobe |
| mask_data_i | input | 8 | New mask, 1 blocks the level |
| cmd_we_i | input | 1 | Command strobe |
| cmd_rot_i | input | 1 | Command bit 2 (rotate) |
| cmd_sel_i | input | 1 | Command bit 1 (use level operand) |
| cmd_eoi_i | input | 1 | Command bit 0 (end of interrupt) |
| cmd_lvl_i | input | 3 | Level operand of the command |
| ack_i | input | 1 | Acknowledge strobe |
| irq_o | output | 1 | Interrupt output |
| win_valid_o | output | 1 | An unmasked request is pending |
| win_lvl_o | output | 3 | Highest-ranked unmasked pending level |
| pend_o | output | 8 | Request register |
| insvc_o | output | 8 | In-service register |
| mask_o | output | 8 | Mask register |
| low_o | output | 3 | Current lowest-priority level |

## Verification
The properties assume that a command and an acknowledge are never strobed in the same cycle, because the in-service checks hold only while one of them acts alone. The stimulus drives every strobe for exactly one cycle and spaces commands and acknowledges apart. The properties also take the command level operand as stable during its strobe, and the bench changes inputs only on the falling clock edge.

// File: rtl/pir_pkg.sv
package pir_pkg;

  typedef enum logic [2:0] {
    CMD_AEOI_ROT_OFF = 3'b000,
    CMD_NS_EOI       = 3'b001,
    CMD_NOP          = 3'b010,
    CMD_S_EOI        = 3'b011,
    CMD_AEOI_ROT_ON  = 3'b100,
    CMD_ROT_NS_EOI   = 3'b101,
    CMD_SET_LOW      = 3'b110,
    CMD_ROT_S_EOI    = 3'b111
  } pir_cmd_e;

  typedef struct packed {
    logic clr_top;     // clear highest-ranked in-service bit
    logic clr_named;   // clear in-service bit named by operand
    logic low_top;     // make cleared top level the lowest
    logic low_named;   // make operand level the lowest
    logic flag_set;    // rotate on automatic EOI: on
    logic flag_clr;    // rotate on automatic EOI: off
  } pir_act_t;

  function automatic pir_act_t pir_decode(pir_cmd_e c);
    pir_act_t a;
    a = '0;
    unique case (c)
      CMD_NS_EOI:       a.clr_top = 1'b1;
      CMD_S_EOI:        a.clr_named = 1'b1;
      CMD_ROT_NS_EOI:   begin a.clr_top = 1'b1; a.low_top = 1'b1; end
      CMD_ROT_S_EOI:    begin a.clr_named = 1'b1; a.low_named = 1'b1; end
      CMD_SET_LOW:      a.low_named = 1'b1;
      CMD_AEOI_ROT_ON:  a.flag_set = 1'b1;
      CMD_AEOI_ROT_OFF: a.flag_clr = 1'b1;
      default:          a = '0;
    endcase
    return a;
  endfunction

  // Rank of a level in the ring: 0 = highest, n-1 = the lowest level itself.
  function automatic int unsigned ring_rank(int unsigned lvl, int unsigned low,
                                            int unsigned n);
    return (lvl + n + n - low - 1) % n;
  endfunction

endpackage

// File: rtl/pir_cmd_unit.sv
module pir_cmd_unit
  import pir_pkg::*;
(
  input  logic     we_i,
  input  logic     rot_i,
  input  logic     sel_i,
  input  logic     eoi_i,
  output pir_act_t act_o
);

  pir_cmd_e code;

  always_comb begin
    code  = pir_cmd_e'({rot_i, sel_i, eoi_i});
    act_o = we_i ? pir_decode(code) : '0;
  end

endmodule

// File: rtl/pir_req_capture.sv
module pir_req_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_i,
  input  logic         level_mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o
);

  logic [N-1:0] prev_q;
  logic [N-1:0] rise;
  logic [N-1:0] req_next;

  assign rise = lines_i & ~prev_q;

  always_comb begin
    if (level_mode_i) req_next = lines_i & ~clr_i;
    else              req_next = (req_o & ~clr_i) | rise;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_o  <= '0;
    end else begin
      prev_q <= lines_i;
      req_o  <= req_next;
    end
  end

endmodule

// File: rtl/pir_ring_pick.sv
module pir_ring_pick
  import pir_pkg::*;
#(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] low_i,
  output logic          found_o,
  output logic [LW-1:0] lvl_o,
  output logic [LW-1:0] rank_o
);

  int unsigned best;

  always_comb begin
    best  = N;
    lvl_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i] && ring_rank(i, 32'(low_i), N) < best) begin
        best  = ring_rank(i, 32'(low_i), N);
        lvl_o = LW'(i);
      end
    end
    found_o = (best != N);
    rank_o  = LW'(best);
  end

endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
  import pir_pkg::*;
#(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_lines_i,
  input  logic          level_mode_i,
  input  logic          aeoi_en_i,
  input  logic          mask_we_i,
  input  logic [N-1:0]  mask_data_i,
  input  logic          cmd_we_i,
  input  logic          cmd_rot_i,
  input  logic          cmd_sel_i,
  input  logic          cmd_eoi_i,
  input  logic [LW-1:0] cmd_lvl_i,
  input  logic          ack_i,
  output logic          irq_o,
  output logic          win_valid_o,
  output logic [LW-1:0] win_lvl_o,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  insvc_o,
  output logic [N-1:0]  mask_o,
  output logic [LW-1:0] low_o
);

  function automatic logic [N-1:0] lvl_bit(input logic [LW-1:0] l);
    logic [N-1:0] v;
    v = '0;
    v[l] = 1'b1;
    return v;
  endfunction

  pir_act_t      act;
  logic [N-1:0]  req_q, mask_q, isr_q, pending;
  logic [LW-1:0] low_q, low_next;
  logic          aeoi_rot_q;

  logic          win_found, svc_found;
  logic [LW-1:0] win_lvl, win_rank, svc_lvl, svc_rank;

  // named internal events
  logic          irq_hit;
  logic          ack_take;
  logic [N-1:0]  ack_clr;
  logic [N-1:0]  eoi_clr;
  logic [N-1:0]  isr_set;

  pir_cmd_unit u_cmd (
    .we_i  (cmd_we_i),
    .rot_i (cmd_rot_i),
    .sel_i (cmd_sel_i),
    .eoi_i (cmd_eoi_i),
    .act_o (act)
  );

  pir_req_capture #(.N(N)) u_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .lines_i      (irq_lines_i),
    .level_mode_i (level_mode_i),
    .clr_i        (ack_clr),
    .req_o        (req_q)
  );

  assign pending = req_q & ~mask_q;

  pir_ring_pick #(.N(N)) u_pick_req (
    .vec_i   (pending),
    .low_i   (low_q),
    .found_o (win_found),
    .lvl_o   (win_lvl),
    .rank_o  (win_rank)
  );

  pir_ring_pick #(.N(N)) u_pick_isr (
    .vec_i   (isr_q),
    .low_i   (low_q),
    .found_o (svc_found),
    .lvl_o   (svc_lvl),
    .rank_o  (svc_rank)
  );

  assign irq_hit  = win_found && (!svc_found || (win_rank < svc_rank));
  assign ack_take = ack_i && irq_hit;
  assign ack_clr  = ack_take ? lvl_bit(win_lvl) : '0;
  assign isr_set  = (ack_take && !aeoi_en_i) ? lvl_bit(win_lvl) : '0;
  assign eoi_clr  = ((act.clr_top && svc_found) ? lvl_bit(svc_lvl) : '0)
                  | (act.clr_named ? lvl_bit(cmd_lvl_i) : '0);

  always_comb begin
    low_next = low_q;
    if (act.low_named)
      low_next = cmd_lvl_i;
    else if (act.low_top && svc_found)
      low_next = svc_lvl;
    else if (ack_take && aeoi_en_i && aeoi_rot_q)
      low_next = win_lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= '0;
      isr_q      <= '0;
      low_q      <= LW'(N - 1);
      aeoi_rot_q <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_data_i;
      isr_q <= (isr_q & ~eoi_clr) | isr_set;
      low_q <= low_next;
      if (act.flag_set)      aeoi_rot_q <= 1'b1;
      else if (act.flag_clr) aeoi_rot_q <= 1'b0;
    end
  end

  assign irq_o       = irq_hit;
  assign win_valid_o = win_found;
  assign win_lvl_o   = win_lvl;
  assign pend_o      = req_q;
  assign insvc_o     = isr_q;
  assign mask_o      = mask_q;
  assign low_o       = low_q;

endmodule

// File: rtl/pir_checks.sv
module pir_checks #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          aeoi_en,
  input logic          cmd_we,
  input logic [2:0]    cmd_code,
  input logic [LW-1:0] cmd_lvl,
  input logic          irq,
  input logic          win_valid,
  input logic [LW-1:0] win_lvl,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  insvc,
  input logic [N-1:0]  mask,
  input logic [LW-1:0] low
);

  assert_irq_needs_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> win_valid);

  assert_winner_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (pend[win_lvl] && !mask[win_lvl]));

  assert_ack_enters_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !aeoi_en && !cmd_we) |=> insvc[$past(win_lvl)]);

  assert_idle_ack_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !cmd_we) |=> ($stable(insvc) && $stable(low)));

  assert_set_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == 3'b110 && !ack) |=> (low == $past(cmd_lvl) && $stable(insvc)));

  assert_specific_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code[1:0] == 2'b11 && !ack) |=> !insvc[$past(cmd_lvl)]);

  assert_aeoi_keeps_isr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && aeoi_en && !cmd_we) |=> $stable(insvc));

  assert_quiet_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !cmd_we) |=> ($stable(insvc) && $stable(low)));

endmodule

bind prio_irq_resolver pir_checks #(.N(N)) u_pir_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack       (ack_i),
  .aeoi_en   (aeoi_en_i),
  .cmd_we    (cmd_we_i),
  .cmd_code  ({cmd_rot_i, cmd_sel_i, cmd_eoi_i}),
  .cmd_lvl   (cmd_lvl_i),
  .irq       (irq_o),
  .win_valid (win_valid_o),
  .win_lvl   (win_lvl_o),
  .pend      (pend_o),
  .insvc     (insvc_o),
  .mask      (mask_o),
  .low       (low_o)
);

// File: tb/test_prio_irq_resolver.sv
`timescale 1ns/1ps
module test_prio_irq_resolver;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lines = '0;
  logic       lvl_mode = 1'b1;
  logic       aeoi = 1'b0;
  logic       mwe = 1'b0;
  logic [7:0] mdat = '0;
  logic       cwe = 1'b0;
  logic [2:0] ccode = '0;
  logic [2:0] clvl = '0;
  logic       ack = 1'b0;
  logic       irq, wv;
  logic [2:0] wl, low;
  logic [7:0] pend, isr, msk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prio_irq_resolver i_prio_irq_resolver (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .level_mode_i(lvl_mode),
    .aeoi_en_i(aeoi), .mask_we_i(mwe), .mask_data_i(mdat), .cmd_we_i(cwe),
    .cmd_rot_i(ccode[2]), .cmd_sel_i(ccode[1]), .cmd_eoi_i(ccode[0]),
    .cmd_lvl_i(clvl), .ack_i(ack), .irq_o(irq), .win_valid_o(wv),
    .win_lvl_o(wl), .pend_o(pend), .insvc_o(isr), .mask_o(msk), .low_o(low)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cmd(logic [2:0] c, logic [2:0] l);
    ccode = c; clvl = l; cwe = 1'b1;
    tick();
    cwe = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  // Winner by scanning the ring from the level after the lowest one.
  task automatic ref_win(input int pat, input int lo, output int ok, output int lv);
    ok = 0; lv = 0;
    for (int k = 1; k <= 8; k++) begin
      if (ok == 0 && pat[(lo + k) % 8]) begin ok = 1; lv = (lo + k) % 8; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ok, lv;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 irq", irq, 0); chk("R1 win_valid", wv, 0); chk("R1 pend", pend, 0);
    chk("R1 isr", isr, 0); chk("R1 mask", msk, 0); chk("R1 low", low, 7);

    // R2/R3 sweep of lowest level, request pattern and mask
    for (int lo = 0; lo < 8; lo++) begin
      cmd(3'b110, 3'(lo));
      for (int pat = 0; pat < 256; pat++) begin
        int mv;
        mv = (pat * 37 + lo * 11) & 8'hff;
        lines = 8'(pat); mdat = 8'(mv); mwe = 1'b1;
        tick();
        mwe = 1'b0;
        ref_win(pat & ~mv, lo, ok, lv);
        chk("R3 mask byte", msk, mv);
        chk("R10 level pend", pend, pat);
        chk("R2 win_valid", wv, ok);
        if (ok != 0) chk("R2 win_lvl", wl, lv);
        chk("R3 irq masked", irq, ok);
      end
    end
    lines = '0; mdat = '0; mwe = 1'b1; tick(); mwe = 1'b0;
    cmd(3'b110, 3'd7);
    chk("R8 low back", low, 7);

    // R4/R5/R6 nesting
    lines = 8'h10; tick();
    chk("R4 irq idle", irq, 1); chk("R2 win4", wl, 4);
    do_ack();
    chk("R5 isr set", isr, 8'h10); chk("R5 req cleared", pend, 8'h00);
    tick();
    chk("R10 level returns", pend, 8'h10); chk("R4 equal blocked", irq, 0);
    lines = 8'h14; tick();
    chk("R4 higher passes", irq, 1); chk("R2 win2", wl, 2);
    lines = 8'h54; tick();
    chk("R2 win stays 2", wl, 2);
    do_ack();
    chk("R5 isr two", isr, 8'h14);
    tick();
    chk("R4 nested blocked", irq, 0);
    cmd(3'b001, 3'd0);
    chk("R6 ns eoi top", isr, 8'h10); chk("R4 irq after eoi", irq, 1);
    lines = '0; tick();
    cmd(3'b001, 3'd5);
    chk("R6 ns eoi rest", isr, 0);
    cmd(3'b001, 3'd0);
    chk("R6 empty eoi isr", isr, 0); chk("R6 empty eoi low", low, 7);

    // R6/R7 rotation
    lines = 8'h04; tick();
    do_ack();
    chk("R5 isr lvl2", isr, 8'h04);
    lines = '0;
    cmd(3'b101, 3'd0);
    chk("R6 rot ns isr", isr, 0); chk("R6 rot ns low", low, 2);
    lines = 8'h0A; tick();
    chk("R2 rotated win", wl, 3);
    do_ack();
    chk("R5 isr lvl3", isr, 8'h08);
    lines = '0;
    cmd(3'b111, 3'd3);
    chk("R7 rot s isr", isr, 0); chk("R7 rot s low", low, 3);
    lines = 8'h22; tick();
    chk("R2 win5", wl, 5);
    do_ack();
    chk("R5 isr lvl5", isr, 8'h20);
    cmd(3'b011, 3'd5);
    chk("R7 s eoi isr", isr, 0); chk("R7 s eoi low", low, 3);

    // R8 set lowest with level in service
    tick();
    do_ack();
    chk("R5 isr lvl5 again", isr, 8'h20);
    tick();
    cmd(3'b110, 3'd6);
    chk("R8 low", low, 6); chk("R8 isr kept", isr, 8'h20);
    chk("R2 win1", wl, 1); chk("R4 irq ranked", irq, 1);
    lines = '0;
    cmd(3'b011, 3'd5);
    chk("R7 cleanup", isr, 0);

    // R11 no operation
    lines = 8'h01; tick();
    do_ack();
    lines = '0;
    cmd(3'b010, 3'd0);
    chk("R11 nop isr", isr, 8'h01); chk("R11 nop low", low, 6);
    cmd(3'b011, 3'd0);

    // R9 automatic EOI
    aeoi = 1'b1;
    cmd(3'b110, 3'd7);
    lines = 8'h08; tick();
    do_ack();
    chk("R9 no isr", isr, 0); chk("R9 req cleared", pend, 0); chk("R9 low kept", low, 7);
    cmd(3'b100, 3'd0);
    do_ack();
    chk("R9 rot isr", isr, 0); chk("R9 rot low", low, 3);
    cmd(3'b000, 3'd0);
    cmd(3'b110, 3'd7);
    do_ack();
    chk("R9 rot off low", low, 7);
    lines = '0; aeoi = 1'b0; tick(); tick();

    // R10 edge capture and R5 idle acknowledge
    lvl_mode = 1'b0; tick();
    lines = 8'h40; tick();
    chk("R10 edge set", pend, 8'h40);
    do_ack();
    chk("R10 edge acked", pend, 0); chk("R5 isr lvl6", isr, 8'h40);
    tick(); tick();
    chk("R10 held no reset", pend, 0);
    lines = 8'h00; tick();
    lines = 8'h40; tick();
    lines = 8'h00; tick();
    chk("R10 edge latched", pend, 8'h40);
    lines = 8'hC0; tick();
    chk("R10 second line", pend, 8'hC0);
    cmd(3'b011, 3'd6);
    do_ack();
    chk("R5 isr lvl6 again", isr, 8'h40); chk("R10 lvl7 held", pend, 8'h80);
    chk("R4 lower blocked", irq, 0);
    do_ack();
    chk("R5 idle ack isr", isr, 8'h40); chk("R5 idle ack pend", pend, 8'h80);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule